// File: doc/BRIEF.md
# Microwire Serial Master Sequencer

This block runs half-duplex Microwire transfers for a serial master. Each transfer starts when a control word is taken from the control-word handshake. The control word is shifted out first. Then one or more data words either go out to the slave on the data-out pin or come in from it on the data-in pin. The serial clock is derived from the system clock by a fixed divider parameter. The clock idles low. The master drives a new bit while the clock is low, and both sides sample on the rising edge.

A three-bit mode register sets the behaviour of a transfer. One bit picks sequential block framing over one-word-per-control-word framing. One bit picks the data direction. One bit enables a ready handshake with the slave after the last bit. The register accepts writes only while the master enable input is low. The mode is captured when a transfer starts.

The sequencer walks through the states IDLE, CTRL, LOAD, DATA, TAIL and HSWAIT. IDLE moves to CTRL when a control word is accepted. CTRL moves to LOAD (transmit) or to DATA (receive) after its last bit. LOAD moves to DATA once a transmit word has been taken. DATA moves to LOAD or back to DATA when a sequential block continues, and to TAIL otherwise. TAIL moves to HSWAIT when the handshake is on, and to IDLE when it is off. HSWAIT moves to IDLE on ready or on timeout. BUSY is high in every state except IDLE.

Top module: `uwire_master`

## Requirements
- R1: Out of reset the mode register reads 0 on `cfg_q`, BUSY is low, `cs_n` is high and `sclk` is low. A write with `en` low loads `cfg_wdata` into the register. The field layout is bit 0 = sequential framing, bit 1 = direction (1 = transmit to the slave, 0 = receive from it), bit 2 = ready handshake enable.
- R2: A write to the mode register while `en` is high leaves `cfg_q` unchanged.
- R3: With `en` high in IDLE, a valid control word is accepted (`ctl_ready` is high for that cycle). `cs_n` goes low and the CTL_W control bits appear on `mosi`, MSB first. Each bit lasts 2*HALF_DIV clock cycles and is stable across the rising edge of `sclk`.
- R4: In transmit direction, after the control word one data word is taken from the transmit handshake and shifted out on `mosi`, MSB first, DAT_W bits.
- R5: In receive direction, DAT_W bits are sampled from `miso` on the rising edges of `sclk`, MSB first. The word appears on `rxd_data` with a one-cycle `rxd_valid` pulse.
- R6: In non-sequential framing exactly one data word follows each control word, even if more transmit data is pending or receive space is available.
- R7: In sequential transmit, words keep following the single control word while `txd_valid` is high at the end of a word. `cs_n` stays low for the whole block.
- R8: In sequential receive, another word follows while `rxd_ready` is high at the end of a word. Otherwise the block ends.
- R9: With the handshake disabled, `cs_n` rises after the last bit. BUSY falls 2*HALF_DIV clock cycles (one serial clock period) after the final falling edge of `sclk`.
- R10: With the handshake enabled, `cs_n` is reasserted after the tail period. BUSY stays high while `miso` is low, and falls one cycle after `miso` is seen high.
- R11: With the handshake enabled and the slave never ready, BUSY falls HS_TMO cycles after `cs_n` is reasserted.
- R12: While `en` is low, a pending control word is not accepted and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Master enable; gates new transfers and locks the mode register |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 3 | Mode register write value (bit0 seq, bit1 dir, bit2 handshake) |
| cfg_q | output | 3 | Mode register contents |
| ctl_valid | input | 1 | Control word available |
| ctl_data | input | CTL_W | Control word |
| ctl_ready | output | 1 | Control word taken this cycle |
| txd_valid | input | 1 | Transmit word available |
| txd_data | input | DAT_W | Transmit word |
| txd_ready | output | 1 | Transmit word taken this cycle |
| rxd_ready | input | 1 | Room for another received word (sequential continuation) |
| rxd_valid | output | 1 | Received word pulse |
| rxd_data | output | DAT_W | Received word |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave / ready status |

## Verification
The bench targets the end of each word. A sequencer that checks the continuation condition at the wrong moment sends one word too many or too few in a sequential block. One that ignores the framing bit lets extra pending data leak into a non-sequential transfer. BUSY timing is measured from the last serial clock edge, so an off-by-one tail or a missing tail shows up as a wrong cycle count. Mode register writes are attempted while the master is enabled, to catch a register that is not locked. The handshake is driven with immediate ready, delayed ready and no ready at all, which exposes a sequencer that releases BUSY early, waits forever, or miscounts the timeout.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_LOAD,
        ST_DATA,
        ST_TAIL,
        ST_HSWAIT
    } uw_state_e;

    // Mode register layout: [2] handshake, [1] direction (1 = transmit), [0] sequential
    typedef struct packed {
        logic hs_en;
        logic dir_tx;
        logic seq;
    } uw_cfg_t;

    localparam int UW_CFG_W = 3;

endpackage

// File: rtl/uwire_cfg_reg.sv
module uwire_cfg_reg
    import uwire_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                we,
    input  logic [UW_CFG_W-1:0] wdata,
    output uw_cfg_t             cfg
);

    // Writes land only while the master is disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && !en) begin
            cfg <= uw_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/uwire_bit_timer.sv
module uwire_bit_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_hi,
    output logic smp_stb,
    output logic bit_end
);

    localparam int PERIOD = 2 * HALF;
    localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
    localparam logic [PW-1:0] HALFV = PW'(HALF);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (!run || pcnt == LAST) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    assign sclk_hi = run && (pcnt >= HALFV);
    assign smp_stb = run && (pcnt == HALFV);
    assign bit_end = run && (pcnt == LAST);

endmodule

// File: rtl/uwire_shreg.sv
module uwire_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/uwire_master.sv
module uwire_master
    import uwire_pkg::*;
#(
    parameter int CTL_W    = 8,
    parameter int DAT_W    = 16,
    parameter int HALF_DIV = 2,
    parameter int HS_TMO   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                cfg_we,
    input  logic [UW_CFG_W-1:0] cfg_wdata,
    output logic [UW_CFG_W-1:0] cfg_q,
    input  logic                ctl_valid,
    input  logic [CTL_W-1:0]    ctl_data,
    output logic                ctl_ready,
    input  logic                txd_valid,
    input  logic [DAT_W-1:0]    txd_data,
    output logic                txd_ready,
    input  logic                rxd_ready,
    output logic                rxd_valid,
    output logic [DAT_W-1:0]    rxd_data,
    output logic                busy,
    output logic                sclk,
    output logic                cs_n,
    output logic                mosi,
    input  logic                miso
);

    localparam int MAXW  = (CTL_W > DAT_W) ? CTL_W : DAT_W;
    localparam int BC_W  = (MAXW > 2) ? $clog2(MAXW) : 1;
    localparam int TMO_W = $clog2(HS_TMO + 1);
    localparam logic [BC_W-1:0]  CTL_LAST = BC_W'(CTL_W - 1);
    localparam logic [BC_W-1:0]  DAT_LAST = BC_W'(DAT_W - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(HS_TMO - 1);

    uw_state_e state_q, state_d;
    uw_cfg_t   cfg, cur_cfg;
    logic      cur_dir_tx;

    logic [BC_W-1:0]  bitcnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             run, sclk_hi, smp_stb, bit_end;
    logic             ctrl_last, data_last, more, tmo_hit, start;
    logic [CTL_W-1:0] ctl_q;
    logic [DAT_W-1:0] tx_q, rx_q;
    logic             unused_bits;

    uwire_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    uwire_bit_timer #(.HALF(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sclk_hi (sclk_hi),
        .smp_stb (smp_stb),
        .bit_end (bit_end)
    );

    uwire_shreg #(.W(CTL_W)) u_ctl_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (ctl_data),
        .shift    (state_q == ST_CTRL && bit_end),
        .sin      (1'b0),
        .q        (ctl_q)
    );

    uwire_shreg #(.W(DAT_W)) u_tx_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (txd_valid && txd_ready),
        .load_val (txd_data),
        .shift    (state_q == ST_DATA && cur_dir_tx && bit_end),
        .sin      (1'b0),
        .q        (tx_q)
    );

    uwire_shreg #(.W(DAT_W)) u_rx_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ('0),
        .shift    (state_q == ST_DATA && !cur_dir_tx && smp_stb),
        .sin      (miso),
        .q        (rx_q)
    );

    assign unused_bits = ^{ctl_q[CTL_W-2:0], tx_q[DAT_W-2:0]};
    assign cfg_q       = cfg;
    assign cur_dir_tx  = cur_cfg.dir_tx;

    // Event decode
    assign run       = (state_q == ST_CTRL) || (state_q == ST_DATA) || (state_q == ST_TAIL);
    assign start     = ctl_valid && ctl_ready;
    assign ctrl_last = (state_q == ST_CTRL) && bit_end && (bitcnt == CTL_LAST);
    assign data_last = (state_q == ST_DATA) && bit_end && (bitcnt == DAT_LAST);
    assign more      = cur_cfg.seq && en && (cur_dir_tx ? txd_valid : rxd_ready);
    assign tmo_hit   = (tmo_cnt == TMO_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CTRL;
            ST_CTRL:   if (ctrl_last) state_d = cur_dir_tx ? ST_LOAD : ST_DATA;
            ST_LOAD:   if (txd_valid) state_d = ST_DATA;
            ST_DATA: begin
                if (data_last) begin
                    if (more) state_d = cur_dir_tx ? ST_LOAD : ST_DATA;
                    else      state_d = ST_TAIL;
                end
            end
            ST_TAIL:   if (bit_end) state_d = cur_cfg.hs_en ? ST_HSWAIT : ST_IDLE;
            ST_HSWAIT: if (miso || tmo_hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ctl_ready = 1'b0;
        txd_ready = 1'b0;
        busy      = 1'b1;
        cs_n      = 1'b0;
        sclk      = 1'b0;
        mosi      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctl_ready = en;
                busy      = 1'b0;
                cs_n      = 1'b1;
            end
            ST_CTRL: begin
                sclk = sclk_hi;
                mosi = ctl_q[CTL_W-1];
            end
            ST_LOAD: begin
                txd_ready = 1'b1;
            end
            ST_DATA: begin
                sclk = sclk_hi;
                mosi = cur_dir_tx ? tx_q[DAT_W-1] : 1'b0;
            end
            ST_TAIL: begin
                cs_n = 1'b1;
            end
            ST_HSWAIT: begin
                cs_n = 1'b0;
            end
            default: begin
                busy = 1'b0;
                cs_n = 1'b1;
            end
        endcase
    end

    // Datapath: mode capture, bit count, timeout, received word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cfg   <= '0;
            bitcnt    <= '0;
            tmo_cnt   <= '0;
            rxd_valid <= 1'b0;
            rxd_data  <= '0;
        end else begin
            if (start) begin
                cur_cfg <= cfg;
            end
            if (!run || ctrl_last || data_last) begin
                bitcnt <= '0;
            end else if (bit_end) begin
                bitcnt <= bitcnt + 1'b1;
            end
            if (state_q == ST_HSWAIT) begin
                tmo_cnt <= tmo_cnt + 1'b1;
            end else begin
                tmo_cnt <= '0;
            end
            rxd_valid <= data_last && !cur_dir_tx;
            if (data_last && !cur_dir_tx) begin
                rxd_data <= rx_q;
            end
        end
    end

endmodule

// File: rtl/uwire_master_chk.sv
module uwire_master_chk
    import uwire_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                cfg_we,
    input logic [UW_CFG_W-1:0] cfg_q,
    input logic                ctl_valid,
    input logic                ctl_ready,
    input logic                txd_valid,
    input logic                txd_ready,
    input logic                rxd_valid,
    input logic                busy,
    input logic                cs_n,
    input logic                sclk,
    input logic                cur_dir_tx
);

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg_we) |=> (cfg_q == $past(cfg_q))); // R2

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_ready) |=> busy); // R3

    AST_TX_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_valid && txd_ready) |-> cur_dir_tx); // R4

    AST_RX_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_valid |-> !cur_dir_tx); // R5

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk)); // R9

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !ctl_ready); // R12

endmodule

bind uwire_master uwire_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .cfg_we     (cfg_we),
    .cfg_q      (cfg_q),
    .ctl_valid  (ctl_valid),
    .ctl_ready  (ctl_ready),
    .txd_valid  (txd_valid),
    .txd_ready  (txd_ready),
    .rxd_valid  (rxd_valid),
    .busy       (busy),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .cur_dir_tx (cur_dir_tx)
);

// File: tb/tb_uwire_master.sv
module tb_uwire_master;

    localparam int CW  = 8;
    localparam int DW  = 16;
    localparam int HD  = 2;
    localparam int TMO = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_wdata = '0;
    logic [2:0]    cfg_q;
    logic          ctl_valid = 1'b0;
    logic [CW-1:0] ctl_data = '0;
    logic          ctl_ready;
    logic          txd_valid;
    logic [DW-1:0] txd_data;
    logic          txd_ready;
    logic          rxd_ready;
    logic          rxd_valid;
    logic [DW-1:0] rxd_data;
    logic          busy, sclk, cs_n, mosi, miso;

    always #4 clk = ~clk;

    uwire_master #(.CTL_W(CW), .DAT_W(DW), .HALF_DIV(HD), .HS_TMO(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_ready(ctl_ready),
        .txd_valid(txd_valid), .txd_data(txd_data), .txd_ready(txd_ready),
        .rxd_ready(rxd_ready), .rxd_valid(rxd_valid), .rxd_data(rxd_data),
        .busy(busy), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    int nchk = 0;
    int nfail = 0;

    // Slave model
    logic          cap [0:127];
    int            ncap = 0;
    logic [DW-1:0] txpat [0:7];
    logic [DW-1:0] rxpat [0:7];
    logic [DW-1:0] rx_got [0:7];
    logic          miso_r = 1'b0;
    bit            hs_mode = 1'b0;
    int            sd, sw;
    assign miso = miso_r;

    always @(posedge sclk) begin
        if (ncap < 128) cap[ncap] = mosi;
        ncap++;
    end

    always @(negedge sclk) begin
        if (!hs_mode && ncap >= CW) begin
            sd = ncap - CW;
            sw = sd / DW;
            miso_r = rxpat[sw % 8][DW - 1 - (sd % DW)];
        end
    end

    // Transmit source and receive sink
    int tx_i = 0, tx_n = 0, rx_n = 0, rx_want = 0;
    assign txd_valid = (tx_i < tx_n);
    assign txd_data  = txpat[tx_i % 8];
    assign rxd_ready = (rx_n < rx_want - 1);

    always @(posedge clk) begin
        if (txd_valid && txd_ready) tx_i <= tx_i + 1;
        if (rxd_valid) begin
            if (rx_n < 8) rx_got[rx_n] <= rxd_data;
            rx_n <= rx_n + 1;
        end
    end

    // Edge timing monitor, away from the active edge
    int ncyc = 0, last_fall = 0, busy_fall = 0, cs_falls = 0;
    logic p_sclk = 1'b0, p_busy = 1'b0, p_cs = 1'b1;
    always @(negedge clk) begin
        ncyc++;
        if (p_sclk && !sclk) last_fall = ncyc;
        if (p_busy && !busy) busy_fall = ncyc;
        if (p_cs && !cs_n) cs_falls++;
        p_sclk = sclk;
        p_busy = busy;
        p_cs   = cs_n;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    task automatic write_cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [DW-1:0] cap_word(input int base);
        logic [DW-1:0] v = '0;
        for (int i = 0; i < DW; i++) v = {v[DW-2:0], cap[base + i]};
        return v;
    endfunction

    // One transfer; hs_wait < 0 means the slave never reports ready
    task automatic do_xfer(input bit dir_tx, input bit seq, input bit hs, input int nw, input int hs_wait);
        logic [CW-1:0] ctl;
        logic [CW-1:0] got_ctl;
        int k;
        @(negedge clk);
        en = 1'b0;
        write_cfg({hs, dir_tx, seq});
        for (int i = 0; i < 8; i++) begin
            txpat[i] = DW'($urandom);
            rxpat[i] = DW'($urandom);
        end
        ctl = CW'($urandom);
        ncap = 0;
        tx_i = 0;
        rx_n = 0;
        tx_n = dir_tx ? (seq ? nw : nw + 1) : 0;
        rx_want = dir_tx ? 0 : (seq ? nw : nw + 2);
        cs_falls = 0;
        hs_mode = 1'b0;
        miso_r = 1'b0;
        @(negedge clk);
        en = 1'b1;
        ctl_valid = 1'b1;
        ctl_data = ctl;
        do @(negedge clk); while (!busy);
        ctl_valid = 1'b0;
        if (hs) begin
            do @(negedge clk); while (!cs_n);
            hs_mode = 1'b1;
            miso_r = 1'b0;
            do @(negedge clk); while (cs_n);
            if (hs_wait < 0) begin
                k = 0;
                while (busy) begin
                    @(negedge clk);
                    k++;
                end
                chk(k == TMO, "R11 busy release on timeout", k, TMO);
            end else begin
                for (int i = 0; i < hs_wait; i++) @(negedge clk);
                chk(busy == 1'b1, "R10 busy held while slave busy", busy, 1);
                miso_r = 1'b1;
                @(negedge clk);
                chk(busy == 1'b0, "R10 busy release after ready", busy, 0);
            end
            @(negedge clk);
            chk(cs_falls == 2, "R10 select reasserted for ready check", cs_falls, 2);
        end else begin
            do @(negedge clk); while (busy);
            @(negedge clk);
            chk(busy_fall - last_fall == 2 * HD, "R9 busy clears one serial period after last bit",
                busy_fall - last_fall, 2 * HD);
            chk(cs_falls == 1, "R7 select held for the block", cs_falls, 1);
        end
        hs_mode = 1'b0;
        got_ctl = '0;
        for (int i = 0; i < CW; i++) got_ctl = {got_ctl[CW-2:0], cap[i]};
        chk(got_ctl == ctl, "R3 control word MSB first", got_ctl, ctl);
        chk(ncap == CW + DW * nw, "R6 serial clock count per transfer", ncap, CW + DW * nw);
        if (dir_tx) begin
            chk(tx_i == nw, "R7 transmit words consumed", tx_i, nw);
            for (int w = 0; w < nw; w++)
                chk(cap_word(CW + w * DW) == txpat[w], "R4 transmit word on mosi",
                    cap_word(CW + w * DW), txpat[w]);
        end else begin
            chk(rx_n == nw, "R8 received word count", rx_n, nw);
            for (int w = 0; w < nw && w < 8; w++)
                chk(rx_got[w] == rxpat[w], "R5 received word", rx_got[w], rxpat[w]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(cfg_q == 3'b000, "R1 mode register reset", cfg_q, 0);
        chk(busy == 1'b0 && cs_n == 1'b1 && sclk == 1'b0, "R1 idle pins in reset",
            {busy, cs_n, sclk}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);

        write_cfg(3'b101);
        @(negedge clk);
        chk(cfg_q == 3'b101, "R1 mode write while disabled", cfg_q, 3'b101);
        en = 1'b1;
        write_cfg(3'b010);
        @(negedge clk);
        chk(cfg_q == 3'b101, "R2 mode write ignored while enabled", cfg_q, 3'b101);
        en = 1'b0;
        write_cfg(3'b000);
        @(negedge clk);

        // R12: control word pending with the master disabled
        ctl_valid = 1'b1;
        ctl_data = 8'hA5;
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1, "R12 no start while disabled", {busy, cs_n}, 2'b01);
        ctl_valid = 1'b0;
        @(negedge clk);

        // Directed corner cases
        do_xfer(1'b1, 1'b0, 1'b0, 1, 0);   // R6 transmit, one word per control word
        do_xfer(1'b0, 1'b0, 1'b0, 1, 0);   // R6 receive, one word
        do_xfer(1'b1, 1'b1, 1'b0, 3, 0);   // R7 sequential transmit block
        do_xfer(1'b0, 1'b1, 1'b0, 3, 0);   // R8 sequential receive block
        do_xfer(1'b0, 1'b1, 1'b0, 1, 0);   // R8 block of a single word
        do_xfer(1'b1, 1'b0, 1'b1, 1, 5);   // R10 delayed ready
        do_xfer(1'b0, 1'b1, 1'b1, 2, 0);   // R10 immediate ready
        do_xfer(1'b1, 1'b0, 1'b1, 1, -1);  // R11 slave never ready

        // Constrained random mix
        for (int n = 0; n < 16; n++) begin
            bit d, s, h;
            int nw;
            d = 1'($urandom);
            s = 1'($urandom);
            h = ($urandom % 4) == 0;
            nw = s ? 1 + int'($urandom % 3) : 1;
            do_xfer(d, s, h, nw, int'($urandom % 6));
        end

        finish_run();
    end

endmodule